// File: doc/BRIEF.md
# Bus-Cycle Fault Register Capture

This block keeps a 16-bit sticky fault word. It records error indications that belong to bus cycles, and edges seen on two asynchronous system-fault lines. The three bus error inputs are active low. They are looked at only when the active-low bus-busy line goes from low to high, which marks the end of a cycle. That includes cycles run by another bus master. Which bit an error lands in depends on who owned the cycle and on whether the cycle addressed memory or I/O.

Software empties the word in one of two ways. A read-and-clear strobe wipes every bit. A write-one-to-clear port wipes only the chosen bits. In both cases a fault that is recorded in the same clock as the clear is kept. A single summary output, the OR of the whole word, serves as the fault interrupt request.

All inputs except the two system-fault lines are taken as synchronous to `clk`. Fault-word bit n, counting with bit 0 as the most significant, sits at vector index 15-n of `fault_word`.

Top module: `bus_fault_capture`

## Requirements
- R1: A synchronous active-high reset clears the whole fault word and drives `any_fault` low.
- R2: Fault-word bit n is output on `fault_word[15-n]`, so fault bit 0 is vector index 15 (value 16'h8000).
- R3: Bus error inputs are sampled only in the clock where `bus_busy_n` is seen high after being low in the previous clock. Errors held while the line stays low, or while it stays high, leave the word unchanged.
- R4: A memory protect error (`prot_err_n` low) sets fault bit 0 (16'h8000) when `own_cycle` is 1, and fault bit 1 (16'h4000) when `own_cycle` is 0.
- R5: A memory parity error (`par_err_n` low) sets fault bit 2 (16'h2000), whatever the owner and cycle type.
- R6: An external address error (`addr_err_n` low) sets fault bit 5 (16'h0400) when `mem_cycle` is 1 (memory cycle), and fault bit 8 (16'h0080) when `mem_cycle` is 0 (I/O cycle).
- R7: A rising edge on `sys_fault0` sets fault bit 7 (16'h0100). The edge passes two synchronizer flops and one history flop, so the bit appears after the third rising clock edge. A level that stays high does not set the bit again after a clear.
- R8: A rising edge on `sys_fault1` sets fault bits 13 and 15 together (16'h0005), with the same delay as R7.
- R9: Bits that are set stay set until a clear, and new faults add to the bits already present.
- R10: `clr_all` zeroes the word. A fault recorded in the same clock survives the clear.
- R11: When `w1c_en` is 1, the word bits where `w1c_mask` holds 1 are cleared and all other bits are kept. A fault recorded in the same clock survives.
- R12: `any_fault` is 1 exactly when at least one bit of the fault word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_busy_n | input | 1 | Bus busy, active low; a low-to-high change ends a cycle |
| own_cycle | input | 1 | 1 when the current bus cycle belongs to this processor |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| prot_err_n | input | 1 | Memory protect error, active low |
| par_err_n | input | 1 | Memory parity error, active low |
| addr_err_n | input | 1 | External address error, active low |
| sys_fault0 | input | 1 | Asynchronous system fault, rising edge |
| sys_fault1 | input | 1 | Asynchronous system fault, rising edge |
| clr_all | input | 1 | Read-and-clear strobe |
| w1c_en | input | 1 | Write-one-to-clear enable |
| w1c_mask | input | 16 | Bits to clear when `w1c_en` is 1 |
| fault_word | output | 16 | Sticky fault word, fault bit 0 at index 15 |
| any_fault | output | 1 | OR of all fault-word bits |

## Verification
A table of bus cycles drives each error alone and in combinations. The table covers all four pairings of owner and cycle type, so that a swapped protect-error owner bit or a swapped memory/I/O address-error bit shows up as a wrong word.

Directed patterns do the rest:
- Errors are held while bus-busy stays low, or stays high, to catch sampling on a level rather than on the trailing edge.
- The system-fault lines are checked one clock before and at the expected delay, and again while held high after a clear, to separate edge capture from level capture.
- Clears are issued alone and in the same clock as a new fault, which shows whether the set or the clear takes priority.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] fword_t;

    // Fault-bit numbers, counted with bit 0 as the most significant bit
    localparam int FB_PROT_OWN   = 0;
    localparam int FB_PROT_OTHER = 1;
    localparam int FB_PARITY     = 2;
    localparam int FB_ADDR_MEM   = 5;
    localparam int FB_SYS0       = 7;
    localparam int FB_ADDR_IO    = 8;
    localparam int FB_SYS1_LO    = 13;
    localparam int FB_SYS1_HI    = 15;

    // Matching vector indices
    localparam int IX_PROT_OWN   = WORD_W - 1 - FB_PROT_OWN;
    localparam int IX_PROT_OTHER = WORD_W - 1 - FB_PROT_OTHER;
    localparam int IX_PARITY     = WORD_W - 1 - FB_PARITY;
    localparam int IX_ADDR_MEM   = WORD_W - 1 - FB_ADDR_MEM;
    localparam int IX_SYS0       = WORD_W - 1 - FB_SYS0;
    localparam int IX_ADDR_IO    = WORD_W - 1 - FB_ADDR_IO;
    localparam int IX_SYS1_LO    = WORD_W - 1 - FB_SYS1_LO;
    localparam int IX_SYS1_HI    = WORD_W - 1 - FB_SYS1_HI;

    localparam int N_ASYNC = 2;

    // Bus errors and qualifiers, all active high after conversion
    typedef struct packed {
        logic own;
        logic mem;
        logic prot;
        logic par;
        logic addr;
    } bus_sample_t;

    // Returns a word with the single fault bit n set (bit 0 = MSB)
    function automatic fword_t fbit(input int n);
        fword_t w;
        w = '0;
        w[WORD_W-1-n] = 1'b1;
        return w;
    endfunction

    // Maps one sampled bus cycle to the bits it sets
    function automatic fword_t steer_bus(input bus_sample_t s);
        fword_t w;
        w = '0;
        if (s.prot) w |= s.own ? fbit(FB_PROT_OWN) : fbit(FB_PROT_OTHER);
        if (s.par)  w |= fbit(FB_PARITY);
        if (s.addr) w |= s.mem ? fbit(FB_ADDR_MEM) : fbit(FB_ADDR_IO);
        return w;
    endfunction

endpackage

// File: rtl/bfc_bus_sampler.sv
module bfc_bus_sampler
    import bfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bus_busy_n,
    input  logic   own_cycle,
    input  logic   mem_cycle,
    input  logic   prot_err_n,
    input  logic   par_err_n,
    input  logic   addr_err_n,
    output fword_t bus_set
);

    logic        busy_q;
    logic        trail_edge;
    bus_sample_t smp;

    // Idle level of bus-busy is high
    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b1;
        else     busy_q <= bus_busy_n;
    end

    assign trail_edge = !busy_q && bus_busy_n;

    always_comb begin
        smp.own  = own_cycle;
        smp.mem  = mem_cycle;
        smp.prot = !prot_err_n;
        smp.par  = !par_err_n;
        smp.addr = !addr_err_n;
    end

    assign bus_set = trail_edge ? steer_bus(smp) : '0;

endmodule

// File: rtl/bfc_edge_sync.sv
module bfc_edge_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            // [0..STAGES-1] synchronizer chain, [STAGES] history for edge detection
            logic [STAGES:0] sh;

            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-1:0], async_in[i]};
            end

            assign rise[i] = sh[STAGES-1] && !sh[STAGES];
        end
    endgenerate

endmodule

// File: rtl/bfc_fault_store.sv
module bfc_fault_store
    import bfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fword_t set_mask,
    input  logic   clr_all,
    input  logic   w1c_en,
    input  fword_t w1c_mask,
    output fword_t fault_word,
    output logic   any_fault
);

    fword_t word_q;
    fword_t clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_all)     clr_mask = '1;
        else if (w1c_en) clr_mask = w1c_mask;
    end

    // New faults take priority over the clear
    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= (word_q & ~clr_mask) | set_mask;
    end

    assign fault_word = word_q;
    assign any_fault  = |word_q;

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && !w1c_en) |=> ((fault_word & $past(fault_word)) == $past(fault_word)));

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && set_mask == '0) |=> (fault_word == '0));

    // R11
    w1c_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (w1c_en && !clr_all) |=> ((fault_word & $past(w1c_mask & ~set_mask)) == '0));

    // R12
    any_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(any_fault) |-> ($past(set_mask) != '0));

endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
    import bfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy_n,
    input  logic              own_cycle,
    input  logic              mem_cycle,
    input  logic              prot_err_n,
    input  logic              par_err_n,
    input  logic              addr_err_n,
    input  logic              sys_fault0,
    input  logic              sys_fault1,
    input  logic              clr_all,
    input  logic              w1c_en,
    input  logic [WORD_W-1:0] w1c_mask,
    output logic [WORD_W-1:0] fault_word,
    output logic              any_fault
);

    fword_t             bus_set;
    fword_t             sys_set;
    fword_t             all_set;
    logic [N_ASYNC-1:0] sys_rise;

    bfc_bus_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .bus_busy_n (bus_busy_n),
        .own_cycle  (own_cycle),
        .mem_cycle  (mem_cycle),
        .prot_err_n (prot_err_n),
        .par_err_n  (par_err_n),
        .addr_err_n (addr_err_n),
        .bus_set    (bus_set)
    );

    bfc_edge_sync #(
        .N      (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({sys_fault1, sys_fault0}),
        .rise     (sys_rise)
    );

    always_comb begin
        sys_set = '0;
        if (sys_rise[0]) sys_set |= fbit(FB_SYS0);
        if (sys_rise[1]) sys_set |= fbit(FB_SYS1_LO) | fbit(FB_SYS1_HI);
    end

    assign all_set = bus_set | sys_set;

    bfc_fault_store u_store (
        .clk        (clk),
        .rst        (rst),
        .set_mask   (all_set),
        .clr_all    (clr_all),
        .w1c_en     (w1c_en),
        .w1c_mask   (w1c_mask),
        .fault_word (fault_word),
        .any_fault  (any_fault)
    );

    // R3
    parity_on_trail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_word[IX_PARITY]) |-> ($past(bus_busy_n) && !$past(bus_busy_n, 2)));

    // R4
    prot_own_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_word[IX_PROT_OWN]) |-> $past(own_cycle));

    // R4
    prot_other_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_word[IX_PROT_OTHER]) |-> !$past(own_cycle));

    // R6
    addr_io_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_word[IX_ADDR_IO]) |-> !$past(mem_cycle));

    // R8
    sys1_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_word[IX_SYS1_LO]) |-> fault_word[IX_SYS1_HI]);

endmodule

// File: tb/bus_fault_capture_bench.sv
module bus_fault_capture_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_busy_n, own_cycle, mem_cycle;
    logic        prot_err_n, par_err_n, addr_err_n;
    logic        sys_fault0, sys_fault1;
    logic        clr_all, w1c_en;
    logic [15:0] w1c_mask;
    logic [15:0] fault_word;
    logic        any_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_fault_capture u_bus_fault_capture (
        .clk(clk), .rst(rst), .bus_busy_n(bus_busy_n), .own_cycle(own_cycle),
        .mem_cycle(mem_cycle), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
        .addr_err_n(addr_err_n), .sys_fault0(sys_fault0), .sys_fault1(sys_fault1),
        .clr_all(clr_all), .w1c_en(w1c_en), .w1c_mask(w1c_mask),
        .fault_word(fault_word), .any_fault(any_fault)
    );

    // {own, mem, prot, par, addr (1 = error asserted), expected word}
    localparam logic [20:0] VECS [0:9] = '{
        {5'b11100, 16'h8000},
        {5'b01100, 16'h4000},
        {5'b11010, 16'h2000},
        {5'b00010, 16'h2000},
        {5'b11001, 16'h0400},
        {5'b10001, 16'h0080},
        {5'b00001, 16'h0080},
        {5'b01111, 16'h6400},
        {5'b10111, 16'hA080},
        {5'b11000, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_any(input string req);
        chk(req, {15'd0, any_fault}, {15'd0, (fault_word != 16'h0)});
    endtask

    task automatic bus_cycle(input logic own, input logic mem, input logic prot,
                             input logic par, input logic addr, input logic clr,
                             input logic w1c, input logic [15:0] mask);
        @(negedge clk);
        bus_busy_n = 1'b0; own_cycle = own; mem_cycle = mem;
        prot_err_n = ~prot; par_err_n = ~par; addr_err_n = ~addr;
        @(negedge clk);
        bus_busy_n = 1'b1; clr_all = clr; w1c_en = w1c; w1c_mask = mask;
        @(negedge clk);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        clr_all = 1'b0; w1c_en = 1'b0; w1c_mask = '0;
    endtask

    task automatic pulse_clear(input logic all, input logic [15:0] mask);
        @(negedge clk);
        clr_all = all; w1c_en = !all; w1c_mask = mask;
        @(negedge clk);
        clr_all = 1'b0; w1c_en = 1'b0; w1c_mask = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_busy_n = 1'b1; own_cycle = 1'b0; mem_cycle = 1'b1;
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        sys_fault0 = 1'b0; sys_fault1 = 1'b0;
        clr_all = 1'b0; w1c_en = 1'b0; w1c_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 word", fault_word, 16'h0000);
        chk("R1 any", {15'd0, any_fault}, 16'h0);

        // R2 R4 R5 R6: table walk, each cycle cleared in the same clock (set wins)
        for (int i = 0; i < 10; i++) begin
            bus_cycle(VECS[i][20], VECS[i][19], VECS[i][18], VECS[i][17], VECS[i][16],
                      1'b1, 1'b0, 16'h0);
            chk($sformatf("R2/R4/R5/R6 vec%0d", i), fault_word, VECS[i][15:0]);
            chk_any("R12 vec");
        end

        // R3: errors held while busy stays low, then while it stays high
        @(negedge clk);
        bus_busy_n = 1'b0; prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 busy low", fault_word, 16'h0000);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        @(negedge clk);
        bus_busy_n = 1'b1;
        @(negedge clk);
        chk("R3 clean edge", fault_word, 16'h0000);
        prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 busy high", fault_word, 16'h0000);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;

        // R7: delay and edge-only capture
        @(negedge clk);
        sys_fault0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 early", fault_word, 16'h0000);
        @(negedge clk);
        chk("R7 set", fault_word, 16'h0100);
        pulse_clear(1'b1, 16'h0);
        repeat (4) @(negedge clk);
        chk("R7 level ignored", fault_word, 16'h0000);
        sys_fault0 = 1'b0;

        // R8
        sys_fault1 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 pair", fault_word, 16'h0005);
        sys_fault1 = 1'b0;

        // R9
        repeat (5) @(negedge clk);
        chk("R9 hold", fault_word, 16'h0005);
        bus_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R9 accumulate", fault_word, 16'h8005);

        // R10: clear with concurrent parity fault
        bus_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R10 set wins", fault_word, 16'h2000);

        // R11
        bus_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R11 setup", fault_word, 16'hA000);
        pulse_clear(1'b0, 16'h8000);
        chk("R11 masked", fault_word, 16'h2000);
        bus_cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h2000);
        chk("R11 set wins", fault_word, 16'h2000);
        pulse_clear(1'b0, 16'h2000);
        chk("R11 last bit", fault_word, 16'h0000);
        // R12
        chk("R12 low", {15'd0, any_fault}, 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule